// File: doc/BRIEF.md
# EEPROM Page-Write Engine

This block is a clocked model of the write engine of a byte-wide EEPROM. A single-cycle write strobe carries an address and a data byte. The first accepted strobe opens a page. Later strobes to the same page fill a 128-byte staging buffer, and each one restarts a load window. When the window runs out with no new write, a programming phase of fixed length starts. At the end of that phase every staged byte is copied into the storage array in one clock edge.

While the engine is busy, a read does not return stored data. It returns a status byte so that software can detect the end of the write. Bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 flips on every read. Once the engine is idle again, reads return array contents.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `busy_o` is low and every array location reads as 8'hFF.
- R2: A write strobe while idle is accepted and `busy_o` is high from the next cycle. The low 7 address bits give the byte offset in the page and the upper address bits give the page number.
- R3: Every accepted write restarts the load window. Programming begins WIN_CYC cycles after the last accepted write edge, and `busy_o` falls exactly WIN_CYC+PROG_CYC cycles after that edge.
- R4: The programming phase lasts PROG_CYC cycles whatever the number of bytes loaded, a single byte included.
- R5: At the end of programming every loaded byte of the page is stored, with the latest byte written to an offset taking precedence. Offsets that were not loaded keep their previous contents.
- R6: A read while busy returns a status byte: bit 7 is the complement of bit 7 of the last accepted byte, and bits 5 to 0 are zero.
- R7: In the status byte, bit 6 is 0 on the first busy read after a page opens and is inverted on each later busy read.
- R8: A write strobe during the programming phase is ignored. It stores nothing and does not change when `busy_o` falls.
- R9: During the load window, a write strobe whose page number differs from the open page is ignored. It stores nothing in either page and does not restart the window.
- R10: A read while idle returns the stored byte at `rd_addr_i` in the next cycle. `rd_data_o` keeps its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte-write strobe |
| wr_addr_i | input | ADDR_W | Write address (page number and byte offset) |
| wr_data_i | input | 8 | Write data byte |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read result or busy status, registered |
| busy_o | output | 1 | High from the first load until programming ends |

## Verification
The engine is exercised with these page patterns:
- A single-byte page shows that programming length does not depend on the byte count.
- A full sequential 128-byte page checks that every offset reaches the array.
- Random sparse pages with repeated offsets separate stored bytes from untouched ones, and check that the last write to an offset wins.

Busy reads are inserted between the loads and are used to poll the last address until it reads back. This checks the inverted bit 7 and the bit 6 sequence, and it checks that true data appears on the first read after the engine goes idle.

Some pages also receive a late strobe for another page, or a strobe during programming. The exact cycle in which `busy_o` falls shows whether such a strobe retriggered the window. The full page readback shows whether it leaked into the array.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_window_timer.sv
module pw_window_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || clr_i)  cnt_q <= '0;
    else if (done_o)           cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int unsigned OFF_W = 7,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_i,
  input  logic [OFF_W-1:0]                   off_i,
  input  logic [BYTE_W-1:0]                  data_i,
  input  logic                               clr_i,
  output logic [(1<<OFF_W)-1:0][BYTE_W-1:0]  data_o,
  output logic [(1<<OFF_W)-1:0]              vld_o
);
  localparam int unsigned SLOTS = 1 << OFF_W;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (off_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g] <= '0;
        vld_o[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_o[g]  <= 1'b0;
      end else if (hit) begin
        data_o[g] <= data_i;
        vld_o[g]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pw_status.sv
module pw_status #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              msb_i,
  input  logic              rd_busy_i,
  output logic [BYTE_W-1:0] status_o
);
  logic tog_q;
  logic msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tog_q <= 1'b0;
    else if (start_i)   tog_q <= 1'b0;
    else if (rd_busy_i) tog_q <= ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   msb_q <= 1'b0;
    else if (wr_i) msb_q <= msb_i;
  end

  assign status_o = {~msb_q, tog_q, {(BYTE_W-2){1'b0}}};
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_OFF_W = 7,
  parameter int unsigned WIN_CYC    = 30000,
  parameter int unsigned PROG_CYC   = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_OFF_W;
  localparam int unsigned DEPTH      = 1 << ADDR_W;
  localparam int unsigned PG_W       = ADDR_W - PAGE_OFF_W;

  pw_state_e state_q, state_d;
  logic [PG_W-1:0]       page_q;
  logic [PG_W-1:0]       wr_page;
  logic [PAGE_OFF_W-1:0] wr_off;
  logic start, accept, win_done, prog_done, rd_busy;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0] stage_data;
  logic [PAGE_BYTES-1:0]             stage_vld;
  logic [BYTE_W-1:0] status;
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rd_q;

  assign wr_page = wr_addr_i[ADDR_W-1:PAGE_OFF_W];
  assign wr_off  = wr_addr_i[PAGE_OFF_W-1:0];
  assign start   = (state_q == ST_IDLE) && wr_en_i;
  assign accept  = start || ((state_q == ST_LOAD) && wr_en_i && (wr_page == page_q));
  assign rd_busy = rd_en_i && (state_q != ST_IDLE);
  assign busy_o  = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)     state_d = ST_LOAD;
      ST_LOAD: if (win_done)  state_d = ST_PROG;
      ST_PROG: if (prog_done) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    page_q <= '0;
    else if (start) page_q <= wr_page;
  end

  // load window: restarted by every accepted byte
  pw_window_timer #(.LEN(WIN_CYC)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_LOAD),
    .clr_i (accept),
    .done_o(win_done)
  );

  pw_window_timer #(.LEN(PROG_CYC)) u_prog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_PROG),
    .clr_i (1'b0),
    .done_o(prog_done)
  );

  pw_page_buf #(.OFF_W(PAGE_OFF_W), .BYTE_W(BYTE_W)) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (accept),
    .off_i (wr_off),
    .data_i(wr_data_i),
    .clr_i (prog_done),
    .data_o(stage_data),
    .vld_o (stage_vld)
  );

  pw_status #(.BYTE_W(BYTE_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .wr_i     (accept),
    .msb_i    (wr_data_i[BYTE_W-1]),
    .rd_busy_i(rd_busy),
    .status_o (status)
  );

  // whole-page commit in one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (prog_done) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (stage_vld[i]) mem[{page_q, PAGE_OFF_W'(i)}] <= stage_data[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= busy_o ? status : mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        rd_data_o,
  input logic              busy_o
);
  p_busy_on_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_en_i) |=> busy_o);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !wr_en_i) |=> !busy_o);

  p_status_low_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_o) |=> (rd_data_o[5:0] == 6'd0));

  p_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_o && $past(rd_en_i) && $past(busy_o))
      |=> (rd_data_o[6] != $past(rd_data_o[6])));

  p_hold_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .rd_data_o(rd_data_o),
  .busy_o   (busy_o)
);

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/100ps
module sim_eeprom_page_writer;
  localparam int AW = 9, OW = 7, WIN = 16, PROG = 40;
  localparam int PB = 1 << OW, NPG = 1 << (AW - OW), DEPTH = 1 << AW;

  logic clk = 0, rst_ni = 0;
  logic wr_en_i = 0, rd_en_i = 0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0, rd_data_o;
  logic busy_o;

  always #2.5 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_OFF_W(OW), .WIN_CYC(WIN), .PROG_CYC(PROG)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o));

  int cyc = 0, fall_cyc = 0, checks = 0, fails = 0;
  logic busy_d = 0;
  logic [7:0] ref_mem [DEPTH];
  logic tog_exp, last_msb;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (busy_d && !busy_o) fall_cyc = cyc;
    busy_d = busy_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d, output int wc);
    @(negedge clk); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 0; wc = cyc;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [7:0] d, output logic was_busy);
    @(negedge clk); was_busy = busy_o; rd_en_i = 1; rd_addr_i = a;
    @(negedge clk); rd_en_i = 0; d = rd_data_o;
  endtask

  function automatic logic [7:0] status_exp();
    return {~last_msb, tog_exp, 6'b0};
  endfunction

  function automatic logic [AW-1:0] mk_addr(input int pg, input int off);
    return AW'((pg << OW) | off);
  endfunction

  task automatic busy_read(input logic [AW-1:0] a, input string req);
    logic [7:0] d; logic wb;
    do_rd(a, d, wb);
    chk({req, " busy during read"}, wb, 1'b1);
    chk({req, " status byte"}, d, status_exp());
    tog_exp = ~tog_exp;
  endtask

  // one page session; seq: sequential offsets; foreign: R9; late: R8; poll: data polling
  task automatic run_page(input int pg, input int n, input bit seq, input bit foreign,
                          input bit late, input bit poll);
    logic [7:0] pend [PB];
    bit pv [PB];
    int wc, dummy, off, fpg, foff, loff;
    logic [AW-1:0] last_a;
    logic [7:0] d; logic wb;
    for (int i = 0; i < PB; i++) pv[i] = 0;
    tog_exp = 0;
    for (int k = 0; k < n; k++) begin
      off = seq ? k : int'($urandom % PB);
      d = 8'($urandom);
      do_wr(mk_addr(pg, off), d, wc);
      pend[off] = d; pv[off] = 1; last_msb = d[7]; last_a = mk_addr(pg, off);
      if (k == 0) chk("R2 busy after first write", busy_o, 1'b1);
      if (!seq && ($urandom % 2) == 1) busy_read(AW'($urandom), "R6 R7 load-phase");
    end
    fpg = (pg + 1) % NPG; foff = 0; loff = 0;
    if (foreign) begin
      repeat (WIN - 5) @(negedge clk);
      foff = int'($urandom % PB);
      do_wr(mk_addr(fpg, foff), ~ref_mem[mk_addr(fpg, foff)], dummy);
    end
    if (late) begin
      repeat (WIN + 2) @(negedge clk);
      loff = int'($urandom % PB);
      while (pv[loff]) loff = (loff + 1) % PB;
      if (n == PB) loff = 0;
      do_wr(mk_addr(pg, loff), ~(pv[loff] ? pend[loff] : ref_mem[mk_addr(pg, loff)]), dummy);
    end
    for (int i = 0; i < PB; i++) if (pv[i]) ref_mem[mk_addr(pg, i)] = pend[i];
    if (poll) begin
      wb = 1;
      while (wb) begin
        do_rd(last_a, d, wb);
        if (wb) begin
          chk("R6 R7 polling status", d, status_exp());
          tog_exp = ~tog_exp;
        end else chk("R5 polling true data", d, ref_mem[last_a]);
      end
    end else begin
      while (busy_o) @(negedge clk);
    end
    @(negedge clk);
    chk("R3 R4 busy fall cycle", 32'(fall_cyc - wc), 32'(WIN + PROG));
    for (int i = 0; i < PB; i++) begin
      do_rd(mk_addr(pg, i), d, wb);
      chk("R5 R10 page readback", d, ref_mem[mk_addr(pg, i)]);
    end
    if (foreign) begin
      do_rd(mk_addr(fpg, foff), d, wb);
      chk("R9 foreign page byte untouched", d, ref_mem[mk_addr(fpg, foff)]);
    end
    if (late) begin
      do_rd(mk_addr(pg, loff), d, wb);
      chk("R8 late write ignored", d, ref_mem[mk_addr(pg, loff)]);
    end
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d; logic wb;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 busy low after reset", busy_o, 1'b0);
    for (int i = 0; i < 6; i++) begin
      do_rd(AW'($urandom), d, wb);
      chk("R1 erased contents", d, 8'hFF);
    end
    run_page(0, 1, 0, 0, 0, 1);   // single byte
    run_page(1, PB, 1, 0, 0, 0);  // full sequential page
    run_page(2, 12, 0, 1, 0, 1);  // foreign page strobe
    run_page(3, 9, 0, 0, 1, 1);   // write during programming
    run_page(1, 5, 0, 1, 1, 0);   // partial rewrite over filled page
    for (int s = 0; s < 6; s++)
      run_page(int'($urandom % NPG), 1 + int'($urandom % 30), 0,
               bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule